// File: doc/BRIEF.md
# Coin-Flip HTHH Pattern Spotter

This block watches a serial stream of coin-flip outcomes, taking one symbol per clock whenever a valid strobe is high. A symbol value of 1 means heads and 0 means tails. The block raises a single-cycle `hit` pulse each time the four most recently accepted symbols form the run heads, tails, heads, heads. The stream has no frames or restart points and can be any length. Occurrences may overlap: the last heads of one match can begin the next.

Internally the block is a five-state machine held in a 3-bit register. On a mismatch, its fallback transitions keep the longest suffix of the history that still begins the pattern, so no occurrence is lost. The `hit` output comes from a register, so it rises one clock after the completing symbol is accepted. Cycles with the strobe low leave the history untouched.

Top module: `coin_seq_spotter`

## Requirements
- R1: While `rst_n` is low, `hit` is 0 and the history is cleared. Symbols accepted before the reset cannot combine with symbols accepted after it to form a match.
- R2: `hit` is 1 in the cycle right after an accepted heads that completes the accepted sequence 1,0,1,1 (H,T,H,H, oldest first). In every other cycle `hit` is 0.
- R3: Overlapping occurrences are all reported. H,T,H,H,T,H,H gives two pulses, on the 4th and 7th symbols.
- R4: A cycle with `sym_valid` = 0 is ignored. The `sym_heads` value in that cycle has no effect, `hit` is 0 in the following cycle, and the partial match is kept across the stall.
- R5: Tails after H,T,H does not discard progress. H,T,H,T,H,H reports one match on the last symbol.
- R6: Two tails in a row break the partial match. H,T,T,H,H reports nothing.
- R7: Repeated heads before the tails are tolerated. H,H,T,H,H reports one match on the last symbol.
- R8: Every `hit` pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| sym_valid | input | 1 | High when `sym_heads` carries a symbol to accept this cycle |
| sym_heads | input | 1 | Symbol value: 1 for heads, 0 for tails |
| hit | output | 1 | One-cycle pulse after the pattern is completed |

## Verification
Every result is due exactly one clock after the symbol that produces it is accepted. `hit` is registered from the current state and the incoming symbol, so nothing else lies on that path. The bench drives each symbol just after a falling edge and lets one rising edge pass. It then compares `hit` at the next falling edge against a reference shift register of accepted symbols that the bench updates at the moment it drives. Stalled cycles and reset cycles use the same one-cycle spacing, so every comparison falls at a fixed point away from the active edge.

// File: rtl/coin_seq_pkg.sv
package coin_seq_pkg;
  localparam int unsigned ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    SEEN_NONE = 3'd0,
    SEEN_H    = 3'd1,
    SEEN_HT   = 3'd2,
    SEEN_HTH  = 3'd3,
    SEEN_FULL = 3'd4
  } seq_state_t;
endpackage

// File: rtl/coin_seq_next.sv
module coin_seq_next
  import coin_seq_pkg::*;
(
  input  seq_state_t cur,
  input  logic       heads,
  output seq_state_t nxt,
  output logic       completes
);
  always_comb begin
    nxt       = SEEN_NONE;
    completes = 1'b0;
    unique case (cur)
      SEEN_NONE: nxt = heads ? SEEN_H : SEEN_NONE;
      SEEN_H:    nxt = heads ? SEEN_H : SEEN_HT;
      SEEN_HT:   nxt = heads ? SEEN_HTH : SEEN_NONE;
      SEEN_HTH: begin
        nxt       = heads ? SEEN_FULL : SEEN_HT;
        completes = heads;
      end
      SEEN_FULL: nxt = heads ? SEEN_H : SEEN_HT;
      default:   nxt = SEEN_NONE;
    endcase
  end
endmodule

// File: rtl/coin_seq_pulse.sv
module coin_seq_pulse #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  logic pulse_d;

  always_comb begin
    pulse_d = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= RESET_VAL;
    else        pulse <= pulse_d;
  end
endmodule

// File: rtl/coin_seq_spotter.sv
module coin_seq_spotter
  import coin_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sym_valid,
  input  logic sym_heads,
  output logic hit
);
  seq_state_t state_q;
  seq_state_t state_step;
  seq_state_t state_d;
  logic       step_completes;
  logic       fire;

  coin_seq_next u_next (
    .cur       (state_q),
    .heads     (sym_heads),
    .nxt       (state_step),
    .completes (step_completes)
  );

  always_comb begin
    state_d = state_q;
    if (sym_valid) state_d = state_step;
    fire = sym_valid & step_completes;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEEN_NONE;
    else        state_q <= state_d;
  end

  coin_seq_pulse #(.RESET_VAL(1'b0)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .pulse (hit)
  );
endmodule

// File: rtl/coin_seq_spotter_chk.sv
module coin_seq_spotter_chk
  import coin_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sym_valid,
  input logic       sym_heads,
  input logic       hit,
  input seq_state_t state_q
);
  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);

  // R4
  stall_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |=> !hit);

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |=> $stable(state_q));

  // R2
  hit_after_heads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_heads && state_q == SEEN_HTH) |=> hit);

  // R2
  hit_in_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (state_q == SEEN_FULL));

  // R6
  double_tails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !sym_heads && state_q == SEEN_HT) |=> (state_q == SEEN_NONE));

  // R1
  legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q inside {SEEN_NONE, SEEN_H, SEEN_HT, SEEN_HTH, SEEN_FULL});
endmodule

bind coin_seq_spotter coin_seq_spotter_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sym_valid (sym_valid),
  .sym_heads (sym_heads),
  .hit       (hit),
  .state_q   (state_q)
);

// File: tb/coin_seq_spotter_test.sv
`timescale 1ns/1ps
module coin_seq_spotter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_valid = 1'b0;
  logic sym_heads = 1'b0;
  logic hit;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;
  logic [3:0] hist = 4'b0;
  int seen = 0;

  always #5 clk = ~clk;

  coin_seq_spotter uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_valid (sym_valid),
    .sym_heads (sym_heads),
    .hit       (hit)
  );

  function automatic logic model_accept(logic h);
    hist = {hist[2:0], h};
    if (seen < 4) seen = seen + 1;
    return (seen == 4) && (hist == 4'b1011);
  endfunction

  task automatic check(string tag, logic got, logic exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s: hit=%0b expected=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(string tag, logic v, logic h);
    logic exp;
    sym_valid = v;
    sym_heads = h;
    exp = v ? model_accept(h) : 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(tag, hit, exp);
  endtask

  task automatic feed(string tag, string s);
    for (int i = 0; i < s.len(); i++) step(tag, 1'b1, s[i] == "H");
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sym_valid = 1'b0;
    hist = 4'b0;
    seen = 0;
    @(posedge clk);
    @(negedge clk);
    check("R1", hit, 1'b0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: hit=%0b expected=finish", hit);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R2 basic match
    feed("R2", "HTHH");
    step("R8", 1'b1, 1'b0);
    // R3 overlap
    do_reset();
    feed("R3", "HTHHTHH");
    // R5 fallback from HTH on tails
    do_reset();
    feed("R5", "HTHTHH");
    // R6 double tails break
    do_reset();
    feed("R6", "HTTHH");
    // R7 repeated heads
    do_reset();
    feed("R7", "HHTHH");
    // R4 stalls with junk on the symbol line keep progress
    do_reset();
    step("R4", 1'b1, 1'b1);
    step("R4", 1'b0, 1'b1);
    step("R4", 1'b1, 1'b0);
    step("R4", 1'b0, 1'b0);
    step("R4", 1'b0, 1'b1);
    step("R4", 1'b1, 1'b1);
    step("R4", 1'b0, 1'b0);
    step("R4", 1'b1, 1'b1);
    // R1 reset mid-pattern: HTH then reset then H must not hit
    do_reset();
    feed("R1", "HTH");
    do_reset();
    feed("R1", "H");
    feed("R1", "THH");
    // random mixed stream
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      logic v;
      logic h;
      v = ($urandom_range(0, 3) != 0);
      h = ($urandom_range(0, 4) < 3);
      step("R2", v, h);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule